// File: doc/BRIEF.md
# DMA Burst Length Planner

This block sits in one direction of an Ethernet MAC DMA engine and turns each transfer segment (a start address, a byte count and a flag marking the end of a packet or of a buffer) into a series of bus burst commands. Each command carries a word-aligned address and a beat count. The data bus is 32 bits wide, so one beat moves four bytes. The planner also steers the data beats of each burst. In the receive build (memory write) it forwards packet bytes and fills any space beyond the valid data with zero bytes. In the transmit build (memory read) it forwards the valid bytes of each read beat and throws away beats that fall past the end of the data.

A configured maximum burst length caps every burst. A force enable makes the final burst of an end-of-packet or end-of-buffer segment use the full maximum length even when fewer bytes remain. Bursts never cross a 1 KB address boundary. A burst that would cross one is cut at the boundary, and forcing is not applied where the forced length would cross it. A separate check flags a receive buffer size of zero (the size is counted in 64-byte units) as a configuration error.

The controlling DMA presents one segment at a time and holds the configuration stable while a segment is in flight. Segment start addresses are word aligned.

Top module: `dma_burst_planner`

## Requirements
- R1: Every burst command has a beat count from 1 up to the configured maximum. A configured maximum of 0 acts as 1. Each burst's address is the previous burst's address plus 4 times its beat count, and the first burst starts at the segment address.
- R2: No burst crosses a 1 KB boundary: the command address modulo 1024, plus 4 times the beats, is at most 1024. A burst that would cross is cut at the boundary and the rest continues in the next burst.
- R3: When forcing is off, the last burst of a segment has ceil(remaining bytes / 4) beats.
- R4: When forcing is on and the segment is marked end-of-packet/buffer, the last burst has exactly the configured maximum beats, provided that burst fits below the next 1 KB boundary.
- R5: When the forced length would cross a 1 KB boundary, the last burst keeps its natural length of ceil(remaining / 4) beats.
- R6: When the segment is not marked end-of-packet/buffer, the force enable has no effect on burst lengths.
- R7: Receive build: each burst emits exactly its beat count on dst. Byte lane i (bits 8i+7:8i) carries the next packet byte while valid bytes remain and 0x00 after that, including whole pad beats. Pad beats take nothing from src. dst_keep is 4'hF.
- R8: Transmit build: each burst takes exactly its beat count from src. Beats that hold valid bytes go to dst unchanged, with dst_keep bit i set for each valid byte lane i. Beats past the valid data are taken and never shown on dst.
- R9: A command stays valid with a stable address and beat count until cmd_ready. No new command is shown, and no data moves, until the current burst's data beats are complete, and no data moves while a command is pending.
- R10: seg_done pulses for one cycle, in the cycle after the last command of a segment is accepted. A zero-byte segment produces no command and pulses seg_done in the cycle after it is accepted.
- R11: cfg_err is 1 exactly when the buffer size setting is 0, and 0 for any value from 1 to 255.
- R12: During and just after reset, seg_ready is 1, and cmd_valid, dst_valid and seg_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_valid | input | 1 | Segment request valid |
| seg_ready | output | 1 | Planner idle, segment accepted |
| seg_addr | input | ADDR_W | Segment start address, word aligned |
| seg_bytes | input | CNT_W | Segment length in bytes |
| seg_last | input | 1 | Segment ends a packet or a buffer |
| cfg_max_beats | input | BEAT_W | Maximum beats per burst (0 acts as 1) |
| cfg_force | input | 1 | Force maximum-length final burst |
| cfg_buf_units | input | 8 | Receive buffer size in 64-byte units |
| cfg_err | output | 1 | Buffer size setting illegal (zero) |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Burst command accepted |
| cmd_addr | output | ADDR_W | Burst start address |
| cmd_beats | output | BEAT_W | Burst length in 32-bit beats |
| src_valid | input | 1 | Source beat valid (packet data on receive, read data on transmit) |
| src_ready | output | 1 | Source beat taken |
| src_data | input | 32 | Source beat data |
| dst_valid | output | 1 | Destination beat valid |
| dst_ready | input | 1 | Destination beat taken |
| dst_data | output | 32 | Destination beat data |
| dst_keep | output | 4 | Valid byte lanes of dst_data |
| seg_done | output | 1 | One-cycle pulse after the last command is accepted |

## Verification
Segments are run through both builds with lengths that end on a word edge and lengths that end mid-word, and with forcing on and off, so a wrongly rounded beat count or a forced burst that was not triggered shows up as a wrong command length. Start addresses a few words below a 1 KB edge separate a cut at the boundary from forcing being suppressed. A forced burst that lies wholly below the edge shows that the forced length is applied after the cut. A byte-numbered data pattern shows that receive pad lanes are zero and that transmit residual beats are dropped rather than passed on. A maximum of zero, an unmarked segment with forcing on, a zero-length segment and a stalled command acceptance each test one rule in isolation.

// File: rtl/dbp_pkg.sv
// Shared constants, types and helpers for the DMA burst length planner.
// Assumes a 32-bit data bus and a fixed 1 KB no-crossing window.
package dbp_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_LOG2  = 2;
    localparam int WIN_LOG2   = 10;                  // 1 KB boundary
    localparam int WIN_WORDS  = (1 << WIN_LOG2) / WORD_BYTES;
    localparam int WOFF_W     = WIN_LOG2 - WORD_LOG2; // word offset in window
    localparam int ROOM_W     = WOFF_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    // Lane enables for the low n bytes of a word (n saturates at 4).
    function automatic logic [3:0] lane_mask(input logic [2:0] n);
        logic [3:0] m;
        m = 4'h0;
        for (int i = 0; i < 4; i++) begin
            if (32'(i) < 32'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/dbp_len_calc.sv
// Burst length calculator.
// From the current word offset in the 1 KB window, the remaining byte
// count and the configuration, picks the next burst length and how many
// valid bytes it carries. Purely combinational.
// Assumes CNT_W > ROOM_W so all comparisons share one width.
module dbp_len_calc
    import dbp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BEAT_W = 5
) (
    input  logic [WOFF_W-1:0] word_off,
    input  logic [CNT_W-1:0]  rem_bytes,
    input  logic              seg_last,
    input  logic [BEAT_W-1:0] max_cfg,
    input  logic              force_en,
    output logic [BEAT_W-1:0] beats,
    output logic [CNT_W-1:0]  burst_bytes,
    output logic              is_final,
    output logic              forced
);
    logic [CNT_W-1:0] rem_w;
    logic [CNT_W-1:0] room;
    logic [CNT_W-1:0] mb;
    logic [CNT_W-1:0] nat_a;
    logic [CNT_W-1:0] nat;

    // Remaining words, distance to the window edge, effective maximum.
    always_comb begin
        rem_w = (rem_bytes >> WORD_LOG2) + {{(CNT_W-1){1'b0}}, |rem_bytes[WORD_LOG2-1:0]};
        room  = CNT_W'(ROOM_W'(WIN_WORDS) - {1'b0, word_off});
        mb    = (max_cfg == '0) ? CNT_W'(1) : CNT_W'(max_cfg);
    end

    // Natural length, then optional forcing of the final burst.
    always_comb begin
        nat_a       = (rem_w < mb) ? rem_w : mb;
        nat         = (nat_a < room) ? nat_a : room;
        is_final    = (nat == rem_w);
        forced      = is_final && seg_last && force_en && (mb <= room) && (mb > nat);
        beats       = forced ? mb[BEAT_W-1:0] : nat[BEAT_W-1:0];
        burst_bytes = is_final ? rem_bytes : (nat << WORD_LOG2);
    end
endmodule

// File: rtl/dbp_beat_filter.sv
// Per-beat data steering for one burst.
// Receive build: packs packet bytes, zeroes lanes past the valid count,
// and emits pad beats without taking source data.
// Transmit build: forwards valid read beats with lane enables and
// silently takes residual beats. Combinational; the sequencer owns counters.
module dbp_beat_filter
    import dbp_pkg::*;
#(
    parameter bit IS_RX  = 1'b1,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              active,
    input  logic [CNT_W-1:0]  bytes_left,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data,
    output logic [3:0]        dst_keep,
    output logic              fire
);
    localparam int LANES = DATA_W / 8;

    logic             has_data;
    logic [LANES-1:0] lanes;

    // Lanes that still hold valid bytes in the current beat.
    always_comb begin
        has_data = (bytes_left != '0);
        lanes    = lane_mask((bytes_left >= CNT_W'(WORD_BYTES)) ? 3'd4 : bytes_left[2:0]);
    end

    generate
        if (IS_RX) begin : g_rx
            logic [DATA_W-1:0] packed_data;
            for (genvar i = 0; i < LANES; i++) begin : g_lane
                assign packed_data[8*i +: 8] = lanes[i] ? src_data[8*i +: 8] : 8'h00;
            end
            // Write side: data beats wait on source, pad beats go out as zero.
            always_comb begin
                src_ready = active && has_data && dst_ready;
                dst_valid = active && (has_data ? src_valid : 1'b1);
                dst_data  = has_data ? packed_data : '0;
                dst_keep  = 4'hF;
                fire      = dst_valid && dst_ready;
            end
        end else begin : g_tx
            // Read side: valid beats pass through, residual beats are drained.
            always_comb begin
                src_ready = active && (has_data ? dst_ready : 1'b1);
                dst_valid = active && has_data && src_valid;
                dst_data  = src_data;
                dst_keep  = has_data ? lanes : 4'h0;
                fire      = active && src_valid && src_ready;
            end
        end
    endgenerate
endmodule

// File: rtl/dbp_seq.sv
// Segment sequencer.
// Accepts one segment at a time, presents burst commands one by one,
// then counts the data beats of each burst before offering the next.
// Assumes the configuration is held stable while a segment is active.
module dbp_seq
    import dbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int BEAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [CNT_W-1:0]  seg_bytes,
    input  logic              seg_last,
    input  logic [BEAT_W-1:0] max_cfg,
    // length calculator interface
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_rem,
    output logic              cur_last,
    input  logic [BEAT_W-1:0] lc_beats,
    input  logic [CNT_W-1:0]  lc_bytes,
    input  logic              lc_final,
    // command side
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BEAT_W-1:0] cmd_beats,
    // data side
    output logic              data_active,
    output logic [CNT_W-1:0]  bytes_left,
    input  logic              beat_fire,
    output logic              seg_done
);
    seq_state_e        st;
    logic [BEAT_W-1:0] beats_left;
    logic [CNT_W-1:0]  take;

    assign seg_ready   = (st == ST_IDLE);
    assign cmd_valid   = (st == ST_CMD);
    assign cmd_addr    = cur_addr;
    assign cmd_beats   = lc_beats;
    assign data_active = (st == ST_DATA);

    // Bytes consumed by one beat.
    always_comb take = (bytes_left >= CNT_W'(WORD_BYTES)) ? CNT_W'(WORD_BYTES) : bytes_left;

    // Segment, command and beat bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cur_addr   <= '0;
            cur_rem    <= '0;
            cur_last   <= 1'b0;
            beats_left <= '0;
            bytes_left <= '0;
            seg_done   <= 1'b0;
        end else begin
            seg_done <= 1'b0;
            unique case (st)
                ST_IDLE: if (seg_valid) begin
                    if (seg_bytes == '0) begin
                        seg_done <= 1'b1;
                    end else begin
                        cur_addr <= seg_addr;
                        cur_rem  <= seg_bytes;
                        cur_last <= seg_last;
                        st       <= ST_CMD;
                    end
                end
                ST_CMD: if (cmd_ready) begin
                    cur_addr   <= cur_addr + ADDR_W'({lc_beats, 2'b00});
                    cur_rem    <= cur_rem - lc_bytes;
                    beats_left <= lc_beats;
                    bytes_left <= lc_bytes;
                    seg_done   <= lc_final;
                    st         <= ST_DATA;
                end
                ST_DATA: if (beat_fire) begin
                    beats_left <= beats_left - 1'b1;
                    bytes_left <= bytes_left - take;
                    if (beats_left == BEAT_W'(1)) st <= (cur_rem == '0) ? ST_IDLE : ST_CMD;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1
    beats_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_beats != '0) &&
                      ((max_cfg == '0) ? (cmd_beats == BEAT_W'(1)) : (cmd_beats <= max_cfg)));

    // R2
    no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (int'(cmd_addr[WIN_LOG2-1:0]) + int'(cmd_beats) * WORD_BYTES) <= (1 << WIN_LOG2));

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_beats));

    // R10
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |-> $past(cmd_valid && cmd_ready) || $past(seg_ready && seg_valid && (seg_bytes == '0)));
endmodule

// File: rtl/dma_burst_planner.sv
// DMA burst length planner, top level.
// Splits segments into bursts that never cross 1 KB, optionally forces a
// maximum-length final burst at end of packet/buffer, and steers the data
// beats for the receive (IS_RX=1) or transmit (IS_RX=0) direction.
// Assumes word-aligned segment addresses and configuration held stable
// per segment.
module dma_burst_planner
    import dbp_pkg::*;
#(
    parameter bit IS_RX  = 1'b1,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int BEAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [CNT_W-1:0]  seg_bytes,
    input  logic              seg_last,
    input  logic [BEAT_W-1:0] cfg_max_beats,
    input  logic              cfg_force,
    input  logic [7:0]        cfg_buf_units,
    output logic              cfg_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BEAT_W-1:0] cmd_beats,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [31:0]       src_data,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [31:0]       dst_data,
    output logic [3:0]        dst_keep,
    output logic              seg_done
);
    localparam int DATA_W = WORD_BYTES * 8;

    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_rem;
    logic              cur_last;
    logic [BEAT_W-1:0] lc_beats;
    logic [CNT_W-1:0]  lc_bytes;
    logic              lc_final;
    logic              lc_forced;
    logic              data_active;
    logic [CNT_W-1:0]  bytes_left;
    logic              beat_fire;

    // Zero buffer size is the only illegal setting.
    assign cfg_err = (cfg_buf_units == 8'h00);

    dbp_len_calc #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_len (
        .word_off   (cur_addr[WIN_LOG2-1:WORD_LOG2]),
        .rem_bytes  (cur_rem),
        .seg_last   (cur_last),
        .max_cfg    (cfg_max_beats),
        .force_en   (cfg_force),
        .beats      (lc_beats),
        .burst_bytes(lc_bytes),
        .is_final   (lc_final),
        .forced     (lc_forced)
    );

    dbp_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_valid  (seg_valid),
        .seg_ready  (seg_ready),
        .seg_addr   (seg_addr),
        .seg_bytes  (seg_bytes),
        .seg_last   (seg_last),
        .max_cfg    (cfg_max_beats),
        .cur_addr   (cur_addr),
        .cur_rem    (cur_rem),
        .cur_last   (cur_last),
        .lc_beats   (lc_beats),
        .lc_bytes   (lc_bytes),
        .lc_final   (lc_final),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_addr   (cmd_addr),
        .cmd_beats  (cmd_beats),
        .data_active(data_active),
        .bytes_left (bytes_left),
        .beat_fire  (beat_fire),
        .seg_done   (seg_done)
    );

    dbp_beat_filter #(.IS_RX(IS_RX), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_filt (
        .active    (data_active),
        .bytes_left(bytes_left),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .src_data  (src_data),
        .dst_valid (dst_valid),
        .dst_ready (dst_ready),
        .dst_data  (dst_data),
        .dst_keep  (dst_keep),
        .fire      (beat_fire)
    );

    // R9
    cmd_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !dst_valid && !src_ready);

    // R4
    forced_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && lc_forced) |-> (cmd_beats == cfg_max_beats) && cur_last && cfg_force);
endmodule

// File: tb/tb_dma_burst_planner.sv
`timescale 1ns/1ps
module tb_dma_burst_planner;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // shared stimulus
    logic [31:0] seg_addr = '0;
    logic [15:0] seg_bytes = '0;
    logic        seg_last = 1'b0;
    logic [4:0]  cfg_max = 5'd4;
    logic        cfg_force = 1'b0;
    logic [7:0]  cfg_units = 8'd2;
    logic        dst_ready = 1'b1;

    // receive instance
    logic rx_seg_valid = 1'b0, rx_seg_ready, rx_cfg_err, rx_cmd_valid, rx_cmd_ready = 1'b1;
    logic [31:0] rx_cmd_addr, rx_src_data, rx_dst_data;
    logic [4:0]  rx_cmd_beats;
    logic rx_src_ready, rx_dst_valid, rx_done;
    logic [3:0] rx_keep;
    int rx_idx = 0;

    // transmit instance
    logic tx_seg_valid = 1'b0, tx_seg_ready, tx_cfg_err, tx_cmd_valid;
    logic [31:0] tx_cmd_addr, tx_src_data, tx_dst_data;
    logic [4:0]  tx_cmd_beats;
    logic tx_src_ready, tx_dst_valid, tx_done;
    logic [3:0] tx_keep;
    int tx_idx = 0;

    function automatic logic [31:0] pat(int p);
        return {8'(p + 3), 8'(p + 2), 8'(p + 1), 8'(p)};
    endfunction
    assign rx_src_data = pat(rx_idx);
    assign tx_src_data = pat(tx_idx);

    always @(posedge clk) begin
        if (rx_src_ready) rx_idx <= rx_idx + 4;
        if (tx_src_ready) tx_idx <= tx_idx + 4;
    end

    dma_burst_planner #(.IS_RX(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .seg_valid(rx_seg_valid), .seg_ready(rx_seg_ready),
        .seg_addr(seg_addr), .seg_bytes(seg_bytes), .seg_last(seg_last),
        .cfg_max_beats(cfg_max), .cfg_force(cfg_force), .cfg_buf_units(cfg_units),
        .cfg_err(rx_cfg_err), .cmd_valid(rx_cmd_valid), .cmd_ready(rx_cmd_ready),
        .cmd_addr(rx_cmd_addr), .cmd_beats(rx_cmd_beats), .src_valid(1'b1),
        .src_ready(rx_src_ready), .src_data(rx_src_data), .dst_valid(rx_dst_valid),
        .dst_ready(dst_ready), .dst_data(rx_dst_data), .dst_keep(rx_keep), .seg_done(rx_done)
    );

    dma_burst_planner #(.IS_RX(1'b0)) dut_tx (
        .clk(clk), .rst_n(rst_n), .seg_valid(tx_seg_valid), .seg_ready(tx_seg_ready),
        .seg_addr(seg_addr), .seg_bytes(seg_bytes), .seg_last(seg_last),
        .cfg_max_beats(cfg_max), .cfg_force(cfg_force), .cfg_buf_units(cfg_units),
        .cfg_err(tx_cfg_err), .cmd_valid(tx_cmd_valid), .cmd_ready(1'b1),
        .cmd_addr(tx_cmd_addr), .cmd_beats(tx_cmd_beats), .src_valid(1'b1),
        .src_ready(tx_src_ready), .src_data(tx_src_data), .dst_valid(tx_dst_valid),
        .dst_ready(dst_ready), .dst_data(tx_dst_data), .dst_keep(tx_keep), .seg_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected burst length from the requirements.
    function automatic int exp_beats(int a, int r, bit last, int mb, bit frc);
        int rw, m, room, n;
        rw = (r + 3) / 4;
        m = (mb == 0) ? 1 : mb;
        room = (1024 - (a % 1024)) / 4;
        n = rw;
        if (n > m) n = m;
        if (n > room) n = room;
        if (n == rw && last && frc && m <= room) n = m;
        return n;
    endfunction

    // Run one segment on either build and check every command and beat.
    task automatic run_seg(input bit rx, input int a, input int b, input bit last,
                           input int mb, input bit frc, input string req);
        int r, ac, k, eb, vb, left, wait_n;
        logic [31:0] ed;
        cfg_max = 5'(mb); cfg_force = frc;
        seg_addr = 32'(a); seg_bytes = 16'(b); seg_last = last;
        k = rx ? rx_idx : tx_idx;
        if (rx) rx_seg_valid = 1'b1; else tx_seg_valid = 1'b1;
        @(negedge clk);
        rx_seg_valid = 1'b0; tx_seg_valid = 1'b0;
        r = b; ac = a;
        while (r > 0) begin
            eb = exp_beats(ac, r, last, mb, frc);
            vb = (eb * 4 < r) ? eb * 4 : r;
            wait_n = 0;
            while (!(rx ? rx_cmd_valid : tx_cmd_valid) && wait_n < 50) begin
                @(negedge clk); wait_n++;
            end
            chk(rx ? rx_cmd_valid : tx_cmd_valid, req, "cmd_valid", 0, 1);
            chk((rx ? rx_cmd_addr : tx_cmd_addr) == 32'(ac), "R1", "cmd_addr",
                rx ? rx_cmd_addr : tx_cmd_addr, ac);
            chk(int'(rx ? rx_cmd_beats : tx_cmd_beats) == eb, req, "cmd_beats",
                rx ? rx_cmd_beats : tx_cmd_beats, eb);
            @(negedge clk);
            chk((rx ? rx_done : tx_done) == (r == vb), "R10", "seg_done",
                rx ? rx_done : tx_done, r == vb);
            for (int j = 0; j < eb; j++) begin
                left = vb - 4 * j;
                chk(!(rx ? rx_cmd_valid : tx_cmd_valid), "R9", "cmd during data", 1, 0);
                if (rx) begin
                    ed = '0;
                    for (int i = 0; i < 4; i++) if (i < left) ed[8*i +: 8] = 8'(k + i);
                    chk(rx_dst_valid, "R7", "rx dst_valid", rx_dst_valid, 1);
                    chk(rx_dst_data == ed, "R7", "rx dst_data", rx_dst_data, ed);
                    chk(rx_keep == 4'hF, "R7", "rx keep", rx_keep, 4'hF);
                    if (left > 0) k += 4;
                end else begin
                    if (left > 0) begin
                        ed = pat(k);
                        chk(tx_dst_valid, "R8", "tx dst_valid", tx_dst_valid, 1);
                        chk(tx_dst_data == ed, "R8", "tx dst_data", tx_dst_data, ed);
                        chk(tx_keep == ((left >= 4) ? 4'hF : 4'((1 << left) - 1)), "R8", "tx keep",
                            tx_keep, (left >= 4) ? 4'hF : 4'((1 << left) - 1));
                    end else begin
                        chk(!tx_dst_valid && tx_src_ready, "R8", "residual dropped",
                            {tx_dst_valid, tx_src_ready}, 2'b01);
                    end
                    k += 4;
                end
                @(negedge clk);
            end
            ac += eb * 4; r -= vb;
        end
        chk(rx ? rx_seg_ready : tx_seg_ready, req, "idle after segment", 0, 1);
    endtask

    task automatic t_reset;
        chk(rx_seg_ready && tx_seg_ready, "R12", "seg_ready", {rx_seg_ready, tx_seg_ready}, 2'b11);
        chk(!rx_cmd_valid && !tx_cmd_valid, "R12", "cmd_valid", {rx_cmd_valid, tx_cmd_valid}, 0);
        chk(!rx_dst_valid && !tx_dst_valid, "R12", "dst_valid", {rx_dst_valid, tx_dst_valid}, 0);
        chk(!rx_done && !tx_done, "R12", "seg_done", {rx_done, tx_done}, 0);
    endtask

    task automatic t_zero_len;
        cfg_max = 5'd4; seg_addr = 32'h80; seg_bytes = 16'd0; seg_last = 1'b1;
        rx_seg_valid = 1'b1;
        @(negedge clk);
        rx_seg_valid = 1'b0;
        chk(rx_done, "R10", "zero-length done", rx_done, 1);
        chk(!rx_cmd_valid, "R10", "zero-length no cmd", rx_cmd_valid, 0);
        @(negedge clk);
        chk(!rx_done && !rx_cmd_valid, "R10", "zero-length single pulse", {rx_done, rx_cmd_valid}, 0);
    endtask

    task automatic t_stall;
        logic [31:0] a0;
        logic [4:0]  b0;
        cfg_max = 5'd4; cfg_force = 1'b0;
        seg_addr = 32'h200; seg_bytes = 16'd24; seg_last = 1'b1;
        rx_cmd_ready = 1'b0; rx_seg_valid = 1'b1;
        @(negedge clk);
        rx_seg_valid = 1'b0;
        a0 = rx_cmd_addr; b0 = rx_cmd_beats;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            chk(rx_cmd_valid && rx_cmd_addr == a0 && rx_cmd_beats == b0, "R9", "held cmd",
                {rx_cmd_addr, rx_cmd_beats}, {a0, b0});
            chk(!rx_dst_valid && !rx_src_ready, "R9", "no data while pending",
                {rx_dst_valid, rx_src_ready}, 0);
        end
        rx_cmd_ready = 1'b1;
        for (int s = 0; s < 40 && !rx_seg_ready; s++) @(negedge clk);
        chk(rx_seg_ready, "R9", "stalled segment completes", rx_seg_ready, 1);
    endtask

    task automatic t_cfg;
        cfg_units = 8'd0; #1;
        chk(rx_cfg_err, "R11", "units 0", rx_cfg_err, 1);
        cfg_units = 8'd1; #1;
        chk(!rx_cfg_err, "R11", "units 1", rx_cfg_err, 0);
        cfg_units = 8'hFF; #1;
        chk(!tx_cfg_err, "R11", "units 255", tx_cfg_err, 0);
        cfg_units = 8'd2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_seg(1, 32'h100, 10, 1, 4, 0, "R3");   // unforced short tail
        run_seg(1, 32'h100, 10, 1, 4, 1, "R4");   // forced, pad beat and partial word
        run_seg(1, 32'h000, 100, 1, 8, 1, "R4");  // multi-burst then forced tail
        run_seg(1, 32'h3F0, 40, 1, 16, 1, "R2");  // cut at 1 KB, forced tail after
        run_seg(1, 32'h3F8, 4, 1, 8, 1, "R5");    // force would cross: natural length
        run_seg(1, 32'h040, 10, 0, 4, 1, "R6");   // not end of packet: no forcing
        run_seg(1, 32'h080, 8, 1, 0, 0, "R1");    // max 0 acts as 1
        run_seg(0, 32'h300, 6, 1, 4, 1, "R8");    // tx forced, residual dropped
        run_seg(0, 32'h3F4, 30, 1, 8, 1, "R2");   // tx cut, forced tail crosses? checked
        run_seg(0, 32'h010, 16, 1, 4, 0, "R3");   // tx whole words
        t_zero_len();
        t_stall();
        t_cfg();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule